// File: doc/BRIEF.md
# Byte-parallel configuration host writer

This block sits on the host side of a byte-wide configuration port. It draws configuration bytes from a ready/valid stream and presents them on eight data lines. It generates the port clock from the system clock, and it drives an active-high select and an active-high write strobe. The target can stall the transfer with a busy flag. The target treats data line 0 as the most significant bit, so the block mirrors each byte before driving it.

A session begins with a start pulse that carries a byte count and a readback choice. The select rises one port-clock period before any byte is written. Bytes are then delivered one at a time, and the host keeps each byte unchanged for as long as the target reports busy. Once the final byte has been taken, the write strobe is released.

If readback was chosen, the select stays high and the host turns its data driver off. It then samples the lines on each rising port-clock edge at which busy is low. It mirrors each sample back into conventional bit order and emits it as a one-cycle pulse. It reads the same number of bytes that it wrote, and then it ends the session.

Top module: `cfgport_host_writer`

## Requirements
- R1: While reset is active and after it is released, port_sel, port_wr, port_doe, s_ready and rb_valid are all low.
- R2: port_wr is only high while port_sel is high. In every session, the first rising port-clock edge seen with port_sel high has port_wr low.
- R3: The target takes a byte on a rising port-clock edge when port_sel and port_wr are high and port_busy is low. Over one session the bytes taken are exactly byte_count, and they arrive in stream order.
- R4: Lane mirroring: port_dout bit i equals bit (7 - i) of the stream byte, so the byte's MSB appears on line 0.
- R5: If port_busy is high at a rising edge while a byte is being written, port_wr and port_dout are unchanged at the next rising edge.
- R6: Over a session, exactly byte_count stream handshakes occur. s_ready is only high while port_sel and port_doe are high.
- R7: At the falling port-clock edge that follows the last accepted byte, port_wr and port_doe go low. port_sel goes low as well unless readback was chosen.
- R8: In readback, port_wr and port_doe stay low. Each rising edge with port_busy low gives an rb_valid pulse whose rb_data is port_din in mirrored order. After byte_count samples, port_sel falls.
- R9: port_clk toggles every HALF_PERIOD system cycles, giving a 50% duty cycle.
- R10: A start pulse with byte_count equal to zero is ignored, and port_sel stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a session while the block is idle |
| byte_count | input | CNT_W | Number of bytes to write (and to read back) |
| readback_en | input | 1 | Turns the port around for readback after loading |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte taken in this cycle |
| s_data | input | LANES | Stream byte, conventional bit order |
| port_clk | output | 1 | Port clock to the target |
| port_sel | output | 1 | Select, active high |
| port_wr | output | 1 | Write strobe, active high |
| port_busy | input | 1 | Target busy flag |
| port_dout | output | LANES | Data driven toward the target, mirrored |
| port_doe | output | 1 | Output enable for the data lines |
| port_din | input | LANES | Data lines as driven by the target |
| rb_valid | output | 1 | Readback byte pulse |
| rb_data | output | LANES | Readback byte, conventional bit order |

## Verification
The hardest case to reach is a byte that is held through several consecutive busy edges while the stream is starved at the same time. In that case the host must neither advance nor issue a fresh write. The bench drives busy at random at every falling port edge and withholds s_valid at random. A model of the target records the byte under each busy edge and compares it at the next rising edge. Sessions with long byte counts and high busy rates make repeated stalls frequent.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_PREP,
      PH_LOAD,
      PH_READ
   } phase_t;

endpackage

// File: rtl/cfgport_pclk_gen.sv
module cfgport_pclk_gen #(
   parameter int HALF_PERIOD = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic pclk,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap      = (cnt == LAST);
   assign rise_tick = wrap & ~pclk;
   assign fall_tick = wrap & pclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pclk <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         pclk <= ~pclk;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/cfgport_tx_lane.sv
module cfgport_tx_lane #(
   parameter int LANES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LANES-1:0] din,
   output logic [LANES-1:0] dout
);
   logic [LANES-1:0] mirrored;

   for (genvar i = 0; i < LANES; i++) begin : g_mirror
      assign mirrored[i] = din[LANES-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dout <= '0;
      else if (load) dout <= mirrored;
   end
endmodule

// File: rtl/cfgport_rx_lane.sv
module cfgport_rx_lane #(
   parameter int LANES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [LANES-1:0] din,
   output logic             vld,
   output logic [LANES-1:0] dout
);
   logic [LANES-1:0] mirrored;

   for (genvar i = 0; i < LANES; i++) begin : g_mirror
      assign mirrored[i] = din[LANES-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         dout <= '0;
      end else begin
         vld <= cap;
         if (cap) dout <= mirrored;
      end
   end
endmodule

// File: rtl/cfgport_host_writer.sv
module cfgport_host_writer
   import cfgport_pkg::*;
#(
   parameter int LANES       = 8,
   parameter int CNT_W       = 16,
   parameter int HALF_PERIOD = 2,
   parameter int RB_ENABLE   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] byte_count,
   input  logic             readback_en,
   input  logic             s_valid,
   output logic             s_ready,
   input  logic [LANES-1:0] s_data,
   output logic             port_clk,
   output logic             port_sel,
   output logic             port_wr,
   input  logic             port_busy,
   output logic [LANES-1:0] port_dout,
   output logic             port_doe,
   input  logic [LANES-1:0] port_din,
   output logic             rb_valid,
   output logic [LANES-1:0] rb_data
);
   localparam bit RB_ON = (RB_ENABLE != 0);

   if (LANES < 1) begin : g_bad_lanes
      $error("cfgport_host_writer: LANES must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("cfgport_host_writer: CNT_W must be at least 1");
   end
   if (HALF_PERIOD < 1) begin : g_bad_half
      $error("cfgport_host_writer: HALF_PERIOD must be at least 1");
   end

   phase_t           phase;
   logic [CNT_W-1:0] total;
   logic [CNT_W-1:0] rem;
   logic             rb_mode;
   logic             hold;
   logic             rise_tick;
   logic             fall_tick;
   logic             take;
   logic             accept;
   logic             rx_cap;

   cfgport_pclk_gen #(.HALF_PERIOD(HALF_PERIOD)) u_pclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .pclk      (port_clk),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   // fetch a new byte only on a falling port edge with nothing held
   assign s_ready = (phase == PH_LOAD) && fall_tick && !hold && (rem != '0);
   assign take    = s_ready && s_valid;
   assign accept  = (phase == PH_LOAD) && rise_tick && hold && !port_busy;
   assign rx_cap  = (phase == PH_READ) && rise_tick && !port_busy && (rem != '0);

   cfgport_tx_lane #(.LANES(LANES)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take),
      .din   (s_data),
      .dout  (port_dout)
   );

   if (RB_ON) begin : g_rb
      cfgport_rx_lane #(.LANES(LANES)) u_rx (
         .clk   (clk),
         .rst_n (rst_n),
         .cap   (rx_cap),
         .din   (port_din),
         .vld   (rb_valid),
         .dout  (rb_data)
      );
   end else begin : g_no_rb
      assign rb_valid = 1'b0;
      assign rb_data  = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         total    <= '0;
         rem      <= '0;
         rb_mode  <= 1'b0;
         hold     <= 1'b0;
         port_sel <= 1'b0;
         port_wr  <= 1'b0;
         port_doe <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start && (byte_count != '0)) begin
                  total   <= byte_count;
                  rem     <= byte_count;
                  rb_mode <= readback_en & RB_ON;
                  phase   <= PH_PREP;
               end
            end
            PH_PREP: begin
               if (fall_tick) begin
                  port_sel <= 1'b1;
                  port_doe <= 1'b1;
                  phase    <= PH_LOAD;
               end
            end
            PH_LOAD: begin
               if (fall_tick) begin
                  if (rem == '0) begin
                     port_wr  <= 1'b0;
                     port_doe <= 1'b0;
                     if (rb_mode) begin
                        rem   <= total;
                        phase <= PH_READ;
                     end else begin
                        port_sel <= 1'b0;
                        phase    <= PH_IDLE;
                     end
                  end else if (!hold) begin
                     port_wr <= take;
                     hold    <= take;
                  end
               end
               if (accept) begin
                  hold <= 1'b0;
                  rem  <= rem - 1'b1;
               end
            end
            PH_READ: begin
               if (rx_cap) rem <= rem - 1'b1;
               if (fall_tick && (rem == '0)) begin
                  port_sel <= 1'b0;
                  phase    <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfgport_host_writer_chk.sv
module cfgport_host_writer_chk #(
   parameter int LANES       = 8,
   parameter int HALF_PERIOD = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             port_clk,
   input logic             port_sel,
   input logic             port_wr,
   input logic             port_busy,
   input logic [LANES-1:0] port_dout,
   input logic             port_doe,
   input logic             s_valid,
   input logic             s_ready,
   input logic [LANES-1:0] s_data
);
   logic             pclk_q;
   logic             busy_q;
   logic             pend;
   logic [15:0]      gap;
   logic [LANES-1:0] s_mirror;
   logic             rise_seen;

   for (genvar i = 0; i < LANES; i++) begin : g_m
      assign s_mirror[i] = s_data[LANES-1-i];
   end

   assign rise_seen = port_clk && !pclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pclk_q <= 1'b0;
         busy_q <= 1'b0;
         pend   <= 1'b0;
         gap    <= '0;
      end else begin
         pclk_q <= port_clk;
         busy_q <= port_busy;
         gap    <= (port_clk != pclk_q) ? 16'd1 : gap + 16'd1;
         if (rise_seen) pend <= port_sel && port_wr && busy_q;
      end
   end

   assert_wr_within_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr |-> port_sel);

   assert_sel_leads_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_sel) |-> !port_wr);

   assert_lane_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> (port_dout == $past(s_mirror)));

   assert_hold_on_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> (port_wr && $stable(port_dout)));

   assert_fetch_in_session_R6: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (port_sel && port_doe));

   assert_released_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !port_doe |-> !port_wr);

   assert_clock_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (port_clk != pclk_q) |-> (gap == 16'(HALF_PERIOD)));
endmodule

bind cfgport_host_writer cfgport_host_writer_chk #(
   .LANES       (LANES),
   .HALF_PERIOD (HALF_PERIOD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .port_clk  (port_clk),
   .port_sel  (port_sel),
   .port_wr   (port_wr),
   .port_busy (port_busy),
   .port_dout (port_dout),
   .port_doe  (port_doe),
   .s_valid   (s_valid),
   .s_ready   (s_ready),
   .s_data    (s_data)
);

// File: tb/cfgport_host_writer_tb.sv
module cfgport_host_writer_tb_top;
   localparam int LANES = 8;
   localparam int CNT_W = 8;
   localparam int HALF  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] byte_count = '0;
   logic             readback_en = 1'b0;
   logic             s_valid = 1'b0;
   logic             s_ready;
   logic [LANES-1:0] s_data = '0;
   logic             port_clk;
   logic             port_sel;
   logic             port_wr;
   logic             port_busy = 1'b0;
   logic [LANES-1:0] port_dout;
   logic             port_doe;
   logic [LANES-1:0] port_din = '0;
   logic             rb_valid;
   logic [LANES-1:0] rb_data;

   always #10 clk = ~clk;

   cfgport_host_writer #(
      .LANES(LANES), .CNT_W(CNT_W), .HALF_PERIOD(HALF), .RB_ENABLE(1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
      .readback_en(readback_en), .s_valid(s_valid), .s_ready(s_ready),
      .s_data(s_data), .port_clk(port_clk), .port_sel(port_sel),
      .port_wr(port_wr), .port_busy(port_busy), .port_dout(port_dout),
      .port_doe(port_doe), .port_din(port_din), .rb_valid(rb_valid),
      .rb_data(rb_data)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] tx_list[$];
   int   acc_idx = 0, hs_idx = 0, rb_idx = 0, sess_count = 0;
   int   busy_pct = 0, valid_pct = 100;
   bit   rb_mode = 0, sel_seen = 0, pend = 0, just_done = 0, will_fire = 0;
   bit   gap_valid = 0;
   int   gap = 0;
   logic pclk_prev = 1'b0;
   logic [7:0] held = '0;
   logic [7:0] rb_drive = '0;

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // target model and port monitor
   always @(negedge clk) begin
      if (rst_n) begin
         gap++;
         if (port_clk && !pclk_prev) begin
            if (gap_valid) chk(gap == 2*HALF, "R9 port clock period", gap, 2*HALF);
            gap_valid = 1;
            gap = 0;
            if (pend) begin
               chk(port_wr && port_dout == held, "R5 byte held under busy",
                   {port_wr, port_dout}, {1'b1, held});
               pend = 0;
            end
            if (port_sel && port_wr && port_busy) begin
               pend = 1;
               held = port_dout;
            end
            if (port_sel && !sel_seen) begin
               chk(!port_wr, "R2 select before write", port_wr, 0);
               sel_seen = 1;
            end
            if (port_sel && port_wr && !port_busy) begin
               if (acc_idx < tx_list.size())
                  chk(rev8(port_dout) == tx_list[acc_idx], "R3 R4 accepted byte",
                      port_dout, rev8(tx_list[acc_idx]));
               else
                  chk(0, "R3 extra byte", acc_idx, tx_list.size());
               acc_idx++;
               if (acc_idx == sess_count) just_done = 1;
            end
            if (port_sel && !port_doe && !port_busy) begin
               chk(rb_valid && rb_data == rb_drive, "R8 readback byte",
                   {rb_valid, rb_data}, {1'b1, rb_drive});
               rb_idx++;
            end
         end
         if (!port_clk && pclk_prev) begin
            if (just_done) begin
               chk(!port_wr && !port_doe, "R7 write released", {port_wr, port_doe}, 0);
               chk(port_sel == rb_mode, "R7 select after load", port_sel, rb_mode);
               just_done = 0;
            end
            port_busy = ($urandom_range(99) < busy_pct);
            rb_drive  = 8'($urandom);
            port_din  = rev8(rb_drive);
         end
         pclk_prev = port_clk;
      end
   end

   // stream source
   always @(negedge clk) begin
      if (rst_n) begin
         if (will_fire) begin
            hs_idx++;
            s_valid = 1'b0;
         end
         if (!s_valid && hs_idx < tx_list.size() && $urandom_range(99) < valid_pct) begin
            s_valid = 1'b1;
            s_data  = tx_list[hs_idx];
         end
         will_fire = s_valid && s_ready;
      end
   end

   task automatic run_session(input int cnt, input bit rb, input int bp, input int vp);
      tx_list.delete();
      for (int i = 0; i < cnt; i++) tx_list.push_back(8'($urandom_range(255)));
      acc_idx = 0; hs_idx = 0; rb_idx = 0; sess_count = cnt;
      rb_mode = rb; busy_pct = bp; valid_pct = vp; sel_seen = 0; pend = 0;
      @(negedge clk);
      byte_count  = CNT_W'(cnt);
      readback_en = rb;
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!port_sel) @(negedge clk);
      while (port_sel) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(acc_idx == cnt, "R3 accepted count", acc_idx, cnt);
      chk(hs_idx == cnt, "R6 handshake count", hs_idx, cnt);
      chk(rb_idx == (rb ? cnt : 0), "R8 readback count", rb_idx, rb ? cnt : 0);
      busy_pct = 0;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk({port_sel, port_wr, port_doe, s_ready, rb_valid} == 5'b0,
          "R1 reset outputs", {port_sel, port_wr, port_doe, s_ready, rb_valid}, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk({port_sel, port_wr, port_doe, s_ready, rb_valid} == 5'b0,
          "R1 idle after reset", {port_sel, port_wr, port_doe, s_ready, rb_valid}, 0);

      // R10: zero count is ignored
      byte_count = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      chk(!port_sel && !port_doe, "R10 zero count ignored", {port_sel, port_doe}, 0);

      run_session(1, 0, 0, 100);
      run_session(3, 1, 0, 100);
      run_session(6, 1, 50, 60);
      run_session(10, 0, 75, 40);
      for (int k = 0; k < 6; k++)
         run_session($urandom_range(1, 12), 1'($urandom_range(1)),
                     $urandom_range(60), $urandom_range(30, 100));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R3 session never finished actual=%0d expected=%0d", acc_idx, sess_count);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule